// File: doc/BRIEF.md
# Indexed Block Register Target for a Two-Wire Serial Bus

This block is a target-only device on a two-wire serial bus in the SMBus/I2C style. It answers one fixed 7-bit device address, 1101110. It holds a small file of control bytes, which a clock-distribution block next to it reads in parallel. SCL and SDA are open-drain. The block samples both lines and can pull SDA low, but it never drives SCL.

Every transfer, read or write, has the same shape. The host sends the device address with the direction bit, a starting register index and a byte count N. For a write, the host then sends N data bytes. For a read, the block returns N bytes. Successive bytes go to, or come from, successive register indices.

Indices 0 to 3 are read/write control bytes. Index 4 is a read-only identification byte. Any index above 4 reads as zero and takes no writes. A power-down input holds the serial engine idle and releases SDA. The block does not stretch the clock, check packet error codes, answer the general call or take part in arbitration.

Top module: `smb_ctl_slave`

## Requirements
- R1: A first byte of 1101110 followed by a direction bit is acknowledged (SDA low in the ninth clock). Any other address is not acknowledged, and every later byte up to the next start condition is not acknowledged either.
- R2: In a write (direction bit 0), the host sends an index byte, a count byte N (1 or more) and then N data bytes. Each of these is acknowledged. Data byte k lands in register index+k.
- R3: In a write, a count byte of zero is not acknowledged. No register changes, and the rest of the transfer is ignored.
- R4: In a write, bytes after the N-th data byte are not acknowledged and change no register.
- R5: In a read (direction bit 1), the index and count bytes are acknowledged. The block then shifts out N bytes from successive indices, most significant bit first. It releases SDA after the N-th byte, or as soon as the host does not acknowledge a byte. A count of zero sends no data.
- R6: Index 4 reads as ID_VAL (default 0x22). Writes to index 4 or to any index above 4 are acknowledged but change nothing, and indices above 4 read as 0x00.
- R7: After reset, the four control bytes are 0x07, 0x0F, 0x00 and 0x00 for indices 0 to 3. ctl_regs presents index 0 in bits 7:0, index 1 in bits 15:8, and so on.
- R8: While pwrdn is high, SDA is released, nothing is acknowledged and no register changes, whatever happens on the bus.
- R9: sda_oe and ctl_regs change only after the block has seen SCL low, so SDA stays stable while SCL is high.
- R10: A start condition restarts decoding at the address byte from any state, including in the middle of a transfer. A stop condition returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwrdn | input | 1 | Power-down; holds the serial engine idle while high |
| scl_i | input | 1 | Sampled serial clock line |
| sda_i | input | 1 | Sampled serial data line |
| sda_oe | output | 1 | Pulls SDA low when high |
| ctl_regs | output | 8*NRW | Control bytes, index 0 in the low byte |

## Verification
The bench builds the block with its defaults: four read/write bytes, the identification byte at index 4 with value 0x22, and address 1101110. With these values, one three-byte write starting at index 3 crosses the read/write region, the identification byte and the unmapped space in a single burst. A four-byte read from index 2 then crosses the same edges. The bench bit-bangs the bus with ten system clocks per SCL phase, so each SCL phase is much longer than the two-flop synchroniser delay. It compares ctl_regs against its own register model on every clock while SCL is high.

// File: rtl/smb_ctl_slave.sv
`timescale 1ns/1ps
module smb_ctl_slave #(
  parameter logic [6:0]       DEV_ADDR = 7'b1101110,
  parameter int               NRW      = 4,
  parameter int               ID_IDX   = 4,
  parameter logic [7:0]       ID_VAL   = 8'h22,
  parameter logic [8*NRW-1:0] RST_VAL  = 32'h0000_0F07
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwrdn,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic [8*NRW-1:0] ctl_regs
);

  localparam logic [7:0] ID8 = 8'(ID_IDX);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK, S_SKIP} st_t;
  typedef enum logic [1:0] {P_ADDR, P_OFFS, P_CNT, P_DATA} ph_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end

  wire scl_s    = scl_sy[1];
  wire sda_s    = sda_sy[1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire st_cond  = scl_s & scl_q & sda_q & ~sda_s;
  wire sp_cond  = scl_s & scl_q & ~sda_q & sda_s;

  st_t        st;
  ph_t        ph;
  logic [3:0] bitc;
  logic [7:0] sh, idx, rem;
  logic       rd_mode, ack_m;
  logic [7:0] rf [NRW];
  logic [7:0] rd_byte;

  always_comb begin
    rd_byte = 8'h00;
    if (idx == ID8) rd_byte = ID_VAL;
    for (int i = 0; i < NRW; i++)
      if (idx == 8'(i)) rd_byte = rf[i];
  end

  for (genvar g = 0; g < NRW; g++) begin : g_out
    assign ctl_regs[8*g +: 8] = rf[g];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      ph      <= P_ADDR;
      bitc    <= '0;
      sh      <= '0;
      idx     <= '0;
      rem     <= '0;
      rd_mode <= 1'b0;
      ack_m   <= 1'b0;
      sda_oe  <= 1'b0;
      for (int i = 0; i < NRW; i++) rf[i] <= RST_VAL[8*i +: 8];
    end else if (pwrdn) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else if (st_cond) begin
      st     <= S_RX;
      ph     <= P_ADDR;
      bitc   <= '0;
      sda_oe <= 1'b0;
    end else if (sp_cond) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_RX: begin
          if (scl_rise) begin
            sh   <= {sh[6:0], sda_s};
            bitc <= bitc + 4'd1;
          end else if (scl_fall && bitc == 4'd8) begin
            bitc   <= '0;
            st     <= S_ACK;
            sda_oe <= 1'b1;
            case (ph)
              P_ADDR:
                if (sh[7:1] == DEV_ADDR) begin
                  rd_mode <= sh[0];
                  ph      <= P_OFFS;
                end else begin
                  st     <= S_SKIP;
                  sda_oe <= 1'b0;
                end
              P_OFFS: begin
                idx <= sh;
                ph  <= P_CNT;
              end
              P_CNT: begin
                rem <= sh;
                ph  <= P_DATA;
                if (!rd_mode && sh == 8'h00) begin
                  st     <= S_SKIP;
                  sda_oe <= 1'b0;
                end
              end
              default: begin
                for (int i = 0; i < NRW; i++)
                  if (idx == 8'(i)) rf[i] <= sh;
                idx <= idx + 8'd1;
                rem <= rem - 8'd1;
              end
            endcase
          end
        end
        S_ACK:
          if (scl_fall) begin
            sda_oe <= 1'b0;
            if (ph == P_DATA && rem == 8'h00) st <= S_SKIP;
            else if (ph == P_DATA && rd_mode) begin
              st     <= S_TX;
              sh     <= rd_byte;
              sda_oe <= ~rd_byte[7];
            end else st <= S_RX;
          end
        S_TX: begin
          if (scl_rise) bitc <= bitc + 4'd1;
          else if (scl_fall) begin
            if (bitc == 4'd8) begin
              st     <= S_MACK;
              sda_oe <= 1'b0;
              bitc   <= '0;
              idx    <= idx + 8'd1;
              rem    <= rem - 8'd1;
            end else begin
              sh     <= {sh[6:0], 1'b0};
              sda_oe <= ~sh[6];
            end
          end
        end
        S_MACK: begin
          if (scl_rise) ack_m <= ~sda_s;
          else if (scl_fall) begin
            if (ack_m && rem != 8'h00) begin
              st     <= S_TX;
              sh     <= rd_byte;
              sda_oe <= ~rd_byte[7];
            end else st <= S_SKIP;
          end
        end
        default: sda_oe <= 1'b0;
      endcase
    end

endmodule

// File: rtl/smb_ctl_slave_chk.sv
`timescale 1ns/1ps
module smb_ctl_slave_chk #(
  parameter int               NRW     = 4,
  parameter logic [8*NRW-1:0] RST_VAL = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwrdn,
  input logic             scl_s,
  input logic             sda_oe,
  input logic [8*NRW-1:0] ctl_regs
);

  // R7
  reset_val_chk: assert property (@(posedge clk) !rst_n |=> ctl_regs == RST_VAL);

  // R8
  pwrdn_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn |=> !sda_oe);

  // R8
  pwrdn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn |=> $stable(ctl_regs));

  // R9
  sda_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!$past(scl_s) || $past(pwrdn)));

  // R9
  reg_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctl_regs) |-> !$past(scl_s));

endmodule

bind smb_ctl_slave smb_ctl_slave_chk #(.NRW(NRW), .RST_VAL(RST_VAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwrdn(pwrdn), .scl_s(scl_sy[1]),
  .sda_oe(sda_oe), .ctl_regs(ctl_regs));

// File: tb/smb_ctl_slave_tb.sv
`timescale 1ns/1ps
module smb_ctl_slave_tb;
  localparam int H = 10;
  localparam int Q = 3;
  localparam logic [6:0] ADR = 7'b1101110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwrdn = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic [31:0] ctl_regs;
  wire  sda_bus = m_sda & ~sda_oe;

  always #2.5 clk = ~clk;

  smb_ctl_slave u_dut (
    .clk(clk), .rst_n(rst_n), .pwrdn(pwrdn), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .ctl_regs(ctl_regs));

  int n_cmp = 0;
  int n_bad = 0;
  bit fin = 1'b0;
  logic [7:0] mdl [4];

  function automatic logic [31:0] mvec();
    return {mdl[3], mdl[2], mdl[1], mdl[0]};
  endfunction

  function automatic logic [7:0] ref_rd(input int i);
    if (i < 4) return mdl[i];
    if (i == 4) return 8'h22;
    return 8'h00;
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n && m_scl && !fin) begin
      n_cmp++;
      if (ctl_regs !== mvec()) begin
        n_bad++;
        $display("FAIL R2/R6 model compare: actual %h expected %h", ctl_regs, mvec());
      end
    end

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wclk(H - Q);
    m_scl = 1'b1; wclk(H / 2);
    m_sda = 1'b0; wclk(H / 2);
    m_scl = 1'b0; wclk(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wclk(H - Q);
    m_scl = 1'b1; wclk(H / 2);
    m_sda = 1'b1; wclk(H / 2);
  endtask

  task automatic put_byte(input logic [7:0] b, input bit mw, input int mi, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wclk(H - Q);
      m_scl = 1'b1; wclk(H);
      m_scl = 1'b0; wclk(Q);
    end
    m_sda = 1'b1; wclk(H - Q);
    if (mw && mi < 4) mdl[mi] = b;
    m_scl = 1'b1; wclk(H / 2);
    ack = (sda_bus == 1'b0);
    wclk(H / 2);
    m_scl = 1'b0; wclk(Q);
  endtask

  task automatic get_byte(input bit mack, output logic [7:0] d);
    m_sda = 1'b1;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      wclk(H - Q);
      m_scl = 1'b1; wclk(H / 2);
      d = {d[6:0], sda_bus};
      wclk(H / 2);
      m_scl = 1'b0; wclk(Q);
    end
    m_sda = !mack; wclk(H - Q);
    m_scl = 1'b1; wclk(H);
    m_scl = 1'b0; wclk(Q);
    m_sda = 1'b1;
  endtask

  initial begin
    bit a;
    logic [7:0] d;
    mdl[0] = 8'h07; mdl[1] = 8'h0F; mdl[2] = 8'h00; mdl[3] = 8'h00;
    wclk(4);
    chk("R7 reset", ctl_regs, 32'h0000_0F07);
    chk("R7 sda released", {31'd0, sda_oe}, 32'd0);
    rst_n = 1'b1;
    wclk(5);

    // R1 R2: write two bytes from index 0
    bus_start();
    put_byte({ADR, 1'b0}, 0, 0, a); chk("R1 addr ack", {31'd0, a}, 32'd1);
    put_byte(8'h00, 0, 0, a);       chk("R2 index ack", {31'd0, a}, 32'd1);
    put_byte(8'h02, 0, 0, a);       chk("R2 count ack", {31'd0, a}, 32'd1);
    put_byte(8'hA1, 1, 0, a);       chk("R2 data0 ack", {31'd0, a}, 32'd1);
    put_byte(8'h3C, 1, 1, a);       chk("R2 data1 ack", {31'd0, a}, 32'd1);
    bus_stop();
    chk("R2 regs", ctl_regs, mvec());

    // R5: read four from index 0
    bus_start();
    put_byte({ADR, 1'b1}, 0, 0, a); chk("R5 addr ack", {31'd0, a}, 32'd1);
    put_byte(8'h00, 0, 0, a);       chk("R5 index ack", {31'd0, a}, 32'd1);
    put_byte(8'h04, 0, 0, a);       chk("R5 count ack", {31'd0, a}, 32'd1);
    for (int k = 0; k < 4; k++) begin
      get_byte(k < 3, d);
      chk("R5 read data", {24'd0, d}, {24'd0, ref_rd(k)});
    end
    bus_stop();

    // R3: zero count write
    bus_start();
    put_byte({ADR, 1'b0}, 0, 0, a);
    put_byte(8'h01, 0, 0, a);
    put_byte(8'h00, 0, 0, a);       chk("R3 zero count nack", {31'd0, a}, 32'd0);
    put_byte(8'hFF, 0, 0, a);       chk("R3 following byte nack", {31'd0, a}, 32'd0);
    bus_stop();
    chk("R3 regs unchanged", ctl_regs, mvec());

    // R1: wrong address
    bus_start();
    put_byte({7'h5A, 1'b0}, 0, 0, a); chk("R1 wrong addr nack", {31'd0, a}, 32'd0);
    put_byte(8'h00, 0, 0, a);         chk("R1 ignored byte nack", {31'd0, a}, 32'd0);
    bus_stop();

    // R6: burst across index 3, id byte and unmapped index 5
    bus_start();
    put_byte({ADR, 1'b0}, 0, 0, a);
    put_byte(8'h03, 0, 0, a);
    put_byte(8'h03, 0, 0, a);
    put_byte(8'h5E, 1, 3, a);       chk("R6 index3 ack", {31'd0, a}, 32'd1);
    put_byte(8'h77, 0, 4, a);       chk("R6 id write ack", {31'd0, a}, 32'd1);
    put_byte(8'h88, 0, 5, a);       chk("R6 unmapped ack", {31'd0, a}, 32'd1);
    bus_stop();
    bus_start();
    put_byte({ADR, 1'b1}, 0, 0, a);
    put_byte(8'h02, 0, 0, a);
    put_byte(8'h04, 0, 0, a);
    for (int k = 2; k < 6; k++) begin
      get_byte(k < 5, d);
      chk("R6 read across edges", {24'd0, d}, {24'd0, ref_rd(k)});
    end
    bus_stop();

    // R4: byte beyond count
    bus_start();
    put_byte({ADR, 1'b0}, 0, 0, a);
    put_byte(8'h01, 0, 0, a);
    put_byte(8'h01, 0, 0, a);
    put_byte(8'h55, 1, 1, a);       chk("R4 last data ack", {31'd0, a}, 32'd1);
    put_byte(8'h99, 0, 0, a);       chk("R4 extra byte nack", {31'd0, a}, 32'd0);
    bus_stop();
    chk("R4 regs", ctl_regs, mvec());

    // R5: host nack ends read early, zero count read
    bus_start();
    put_byte({ADR, 1'b1}, 0, 0, a);
    put_byte(8'h00, 0, 0, a);
    put_byte(8'h03, 0, 0, a);
    get_byte(0, d); chk("R5 first byte", {24'd0, d}, {24'd0, ref_rd(0)});
    get_byte(0, d); chk("R5 released after host nack", {24'd0, d}, 32'hFF);
    bus_stop();
    bus_start();
    put_byte({ADR, 1'b1}, 0, 0, a);
    put_byte(8'h01, 0, 0, a);
    put_byte(8'h00, 0, 0, a);       chk("R5 zero count read ack", {31'd0, a}, 32'd1);
    get_byte(0, d); chk("R5 zero count no data", {24'd0, d}, 32'hFF);
    bus_stop();

    // R8: power-down ignores the bus
    pwrdn = 1'b1;
    wclk(4);
    bus_start();
    put_byte({ADR, 1'b0}, 0, 0, a); chk("R8 addr nack in pwrdn", {31'd0, a}, 32'd0);
    put_byte(8'h00, 0, 0, a);
    put_byte(8'h01, 0, 0, a);
    put_byte(8'h00, 0, 0, a);       chk("R8 data nack in pwrdn", {31'd0, a}, 32'd0);
    bus_stop();
    chk("R8 regs held", ctl_regs, mvec());
    pwrdn = 1'b0;
    wclk(4);

    // R10: repeated start mid-write
    bus_start();
    put_byte({ADR, 1'b0}, 0, 0, a);
    put_byte(8'h01, 0, 0, a);
    put_byte(8'h02, 0, 0, a);
    put_byte(8'h11, 1, 1, a);       chk("R10 data before restart", {31'd0, a}, 32'd1);
    bus_start();
    put_byte({ADR, 1'b0}, 0, 0, a); chk("R10 addr after restart", {31'd0, a}, 32'd1);
    put_byte(8'h00, 0, 0, a);
    put_byte(8'h01, 0, 0, a);
    put_byte(8'hEE, 1, 0, a);       chk("R10 data after restart", {31'd0, a}, 32'd1);
    bus_stop();
    chk("R10 regs", ctl_regs, mvec());
    chk("R10 idle after stop", {31'd0, sda_oe}, 32'd0);

    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wclk(150000);
    if (!fin) begin
      fin = 1'b1;
      n_bad++;
      $display("FAIL R10 watchdog: actual done=0 expected done=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule